// File: doc/BRIEF.md
# Queued SPI Wraparound Sequencer

This block is the master-side queue controller of a queued serial peripheral. It keeps a 4-bit queue pointer into 16 queue entries. Each entry holds a command word and a transmit word, and each entry has a matching receive slot. For the entry under the pointer, the sequencer raises a start request to an external shift engine and holds it until the engine returns done. It then writes the engine's received word into the receive slot with the same index and moves to the next entry.

Software sets the run bit with a pulse. Execution begins at the new-queue pointer and runs up to the end-queue pointer. Whenever the end entry completes, a sticky completion flag is set. Without wrapping, the run bit then clears and the sequencer stops. With wrapping, execution goes on from entry zero or from the new-queue pointer, chosen by a target bit. The sequencer can be stopped in three ways. Clearing wrap enable stops it at the next end of queue. Raising halt parks it after the current transfer. A direct clear of the run bit aborts at once. The interrupt output is the flag gated by a buffered copy of the interrupt enable.

Top module: `qspi_wrap_seq`

## Requirements
- R1: After a pulse on `run_set` while idle, entries run in order from `newq_ptr` up to `endq_ptr`, advancing by one modulo 16. With `wrap_en` low, completion of the end entry sets `done_flag`, drops `busy` and leaves `cur_ptr` equal to `endq_ptr`.
- R2: With `wrap_en` high, completion of the end entry keeps `busy` high. The next entry is 0 when `wrap_to_newq` is 0 and `newq_ptr` when it is 1.
- R3: Each completed transfer writes `eng_rxd` into receive slot `cur_ptr`, replacing what an earlier pass left there. The slot is read back through `rx_raddr`/`rx_rdata`.
- R4: `done_flag` rises on every completion of the end entry and stays high until a `flag_clr` pulse.
- R5: `irq` equals `done_flag` AND a registered copy of `irq_en`, and that copy is refreshed only while the flag is low. Lowering `irq_en` while `irq` is high does not drop `irq`.
- R6: After `wrap_en` is lowered during wraparound, the next completion of the end entry sets the flag, drops `busy` and stops.
- R7: While `halt` is high, the transfer in progress still completes, no new `eng_start` is raised, and `halt_ack` goes high. When `halt` is lowered, execution resumes at the entry `cur_ptr` then shows.
- R8: A `run_clr` pulse drops `eng_start` in the same cycle, writes no receive slot for the aborted transfer, and leaves `busy` low in the next cycle.
- R9: `eng_start` stays high, presenting `eng_cmd`/`eng_txd` of entry `cur_ptr`, until `eng_done`. A `run_set` pulse while busy has no effect.
- R10: After reset, `busy`, `done_flag`, `irq`, `halt_ack`, `eng_start` and `cur_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_set | input | 1 | Pulse: start execution when idle |
| run_clr | input | 1 | Pulse: clear run bit, abort at once |
| wrap_en | input | 1 | Continuous wraparound enable |
| wrap_to_newq | input | 1 | Wrap target: 0 = entry 0, 1 = newq_ptr |
| newq_ptr | input | 4 | First entry of the queue |
| endq_ptr | input | 4 | Last entry of the queue |
| halt | input | 1 | Stop after the current transfer |
| flag_clr | input | 1 | Pulse: clear completion flag |
| irq_en | input | 1 | Interrupt enable |
| q_we | input | 1 | Queue entry write strobe |
| q_waddr | input | 4 | Queue entry write index |
| q_wcmd | input | CMD_W | Command word to write |
| q_wtx | input | DATA_W | Transmit word to write |
| rx_raddr | input | 4 | Receive slot read index |
| rx_rdata | output | DATA_W | Receive slot read data |
| eng_start | output | 1 | Transfer request to shift engine |
| eng_cmd | output | CMD_W | Command of current entry |
| eng_txd | output | DATA_W | Transmit word of current entry |
| eng_done | input | 1 | Shift engine completion pulse |
| eng_rxd | input | DATA_W | Word received by shift engine |
| busy | output | 1 | Run bit |
| cur_ptr | output | 4 | Current queue pointer |
| done_flag | output | 1 | Completion flag |
| halt_ack | output | 1 | Idle because of halt |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the interaction between the buffered interrupt enable and a flag that keeps being set again during wraparound. To get there, the bench runs a wrapping queue until the flag is up and lowers the enable while the request stands. It then clears the flag mid-run and waits for the next end of queue, which must now leave the request low. Halt and abort are raised at chosen moments against a bench shift engine with a fixed latency. Its received words differ on every pass, so overwrites of the receive slots can be seen.

// File: rtl/qwrap_pkg.sv
package qwrap_pkg;
    localparam int unsigned QPTR_W = 4;
    localparam int unsigned QDEPTH = 1 << QPTR_W;

    typedef logic [QPTR_W-1:0] qptr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_XFER  = 2'd2
    } qseq_state_e;

    typedef struct packed {
        logic  wr;
        logic  at_end;
        qptr_t idx;
    } qcomplete_t;

    function automatic qptr_t wrap_dest(input logic to_newq, input qptr_t newq);
        return to_newq ? newq : '0;
    endfunction
endpackage

// File: rtl/qwrap_ram.sv
module qwrap_ram #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qwrap_ctrl.sv
module qwrap_ctrl
    import qwrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_set,
    input  logic       run_clr,
    input  logic       wrap_en,
    input  logic       wrap_to_newq,
    input  qptr_t      newq_ptr,
    input  qptr_t      endq_ptr,
    input  logic       halt,
    input  logic       eng_done,
    output logic       eng_start,
    output logic       busy,
    output logic       halt_ack,
    output qptr_t      cur_ptr,
    output qcomplete_t cmpl
);
    qseq_state_e st;
    qptr_t       ptr;
    logic        hack;

    assign cmpl.wr     = (st == ST_XFER) && eng_done && !run_clr;
    assign cmpl.at_end = (ptr == endq_ptr);
    assign cmpl.idx    = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ptr  <= '0;
            hack <= 1'b0;
        end else if (run_clr) begin
            st   <= ST_IDLE;
            hack <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (run_set) begin
                    st  <= ST_READY;
                    ptr <= newq_ptr;
                end
                ST_READY: begin
                    hack <= halt;
                    if (!halt) st <= ST_XFER;
                end
                ST_XFER: if (eng_done) begin
                    if (cmpl.at_end) begin
                        if (wrap_en) begin
                            ptr <= wrap_dest(wrap_to_newq, newq_ptr);
                            st  <= ST_READY;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        ptr <= ptr + 1'b1;
                        st  <= ST_READY;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign eng_start = (st == ST_XFER) && !run_clr;
    assign busy      = (st != ST_IDLE);
    assign halt_ack  = hack;
    assign cur_ptr   = ptr;

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        run_clr |=> !busy && !eng_start);
    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        halt_ack |-> !eng_start);
    assert_single_stop_R1: assert property (@(posedge clk) disable iff (rst)
        cmpl.wr && cmpl.at_end && !wrap_en |=> !busy);
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cmpl.wr && cmpl.at_end && wrap_en && !wrap_to_newq |=> busy && cur_ptr == '0);
    assert_start_hold_R9: assert property (@(posedge clk) disable iff (rst)
        eng_start && !eng_done |=> st == ST_XFER);
endmodule

// File: rtl/qwrap_flag.sv
module qwrap_flag (
    input  logic clk,
    input  logic rst,
    input  logic end_hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic done_flag,
    output logic irq
);
    logic flag_q;
    logic ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (!flag_q) ien_q <= irq_en;
            if (end_hit)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign done_flag = flag_q;
    assign irq       = flag_q && ien_q;

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        done_flag && !flag_clr |=> done_flag);
    assert_irq_kept_R5: assert property (@(posedge clk) disable iff (rst)
        irq && !flag_clr |=> irq);
endmodule

// File: rtl/qspi_wrap_seq.sv
module qspi_wrap_seq
    import qwrap_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CMD_W  = 8,
    localparam int unsigned ENT_W = DATA_W + CMD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_set,
    input  logic              run_clr,
    input  logic              wrap_en,
    input  logic              wrap_to_newq,
    input  logic [QPTR_W-1:0] newq_ptr,
    input  logic [QPTR_W-1:0] endq_ptr,
    input  logic              halt,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              q_we,
    input  logic [QPTR_W-1:0] q_waddr,
    input  logic [CMD_W-1:0]  q_wcmd,
    input  logic [DATA_W-1:0] q_wtx,
    input  logic [QPTR_W-1:0] rx_raddr,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              eng_start,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic [DATA_W-1:0] eng_txd,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rxd,
    output logic              busy,
    output logic [QPTR_W-1:0] cur_ptr,
    output logic              done_flag,
    output logic              halt_ack,
    output logic              irq
);
    qcomplete_t      cmpl;
    logic [ENT_W-1:0] ent_rd;

    qwrap_ctrl u_ctrl (
        .clk(clk), .rst(rst), .run_set(run_set), .run_clr(run_clr),
        .wrap_en(wrap_en), .wrap_to_newq(wrap_to_newq),
        .newq_ptr(newq_ptr), .endq_ptr(endq_ptr), .halt(halt),
        .eng_done(eng_done), .eng_start(eng_start), .busy(busy),
        .halt_ack(halt_ack), .cur_ptr(cur_ptr), .cmpl(cmpl)
    );

    qwrap_flag u_flag (
        .clk(clk), .rst(rst), .end_hit(cmpl.wr && cmpl.at_end),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .done_flag(done_flag), .irq(irq)
    );

    qwrap_ram #(.W(ENT_W), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .we(q_we), .waddr(q_waddr), .wdata({q_wcmd, q_wtx}),
        .raddr(cur_ptr), .rdata(ent_rd)
    );

    qwrap_ram #(.W(DATA_W), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .we(cmpl.wr), .waddr(cmpl.idx), .wdata(eng_rxd),
        .raddr(rx_raddr), .rdata(rx_rdata)
    );

    assign eng_cmd = ent_rd[ENT_W-1:DATA_W];
    assign eng_txd = ent_rd[DATA_W-1:0];
endmodule

// File: tb/qspi_wrap_seq_test.sv
module qspi_wrap_seq_test;
    localparam int DW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_set = 0, run_clr = 0, wrap_en = 0, wrap_to_newq = 0;
    logic [3:0] newq_ptr = 0, endq_ptr = 0, q_waddr = 0, rx_raddr = 0;
    logic halt = 0, flag_clr = 0, irq_en = 0, q_we = 0;
    logic [CW-1:0] q_wcmd = 0;
    logic [DW-1:0] q_wtx = 0;
    logic [DW-1:0] rx_rdata, eng_txd;
    logic [CW-1:0] eng_cmd;
    logic eng_start, busy, done_flag, halt_ack, irq;
    logic [3:0] cur_ptr;
    logic eng_done = 0;
    logic [DW-1:0] eng_rxd = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    qspi_wrap_seq #(.DATA_W(DW), .CMD_W(CW)) uut (
        .clk(clk), .rst(rst), .run_set(run_set), .run_clr(run_clr),
        .wrap_en(wrap_en), .wrap_to_newq(wrap_to_newq), .newq_ptr(newq_ptr),
        .endq_ptr(endq_ptr), .halt(halt), .flag_clr(flag_clr), .irq_en(irq_en),
        .q_we(q_we), .q_waddr(q_waddr), .q_wcmd(q_wcmd), .q_wtx(q_wtx),
        .rx_raddr(rx_raddr), .rx_rdata(rx_rdata), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .eng_txd(eng_txd), .eng_done(eng_done),
        .eng_rxd(eng_rxd), .busy(busy), .cur_ptr(cur_ptr),
        .done_flag(done_flag), .halt_ack(halt_ack), .irq(irq)
    );

    always #10 clk = ~clk;

    // bench shift engine: done three cycles into a request, data changes every transfer
    int eng_cnt = 0;
    logic [DW-1:0] eng_seq = 16'h0100;
    always @(posedge clk) begin
        if (eng_done) begin
            eng_done <= 1'b0;
            eng_cnt  <= 0;
        end else if (eng_start) begin
            if (eng_cnt == 2) begin
                eng_done <= 1'b1;
                eng_rxd  <= eng_txd ^ eng_seq;
                eng_seq  <= eng_seq + 16'h0101;
                eng_cnt  <= 0;
            end else eng_cnt <= eng_cnt + 1;
        end else eng_cnt <= 0;
    end

    // behavioural reference model
    int m_st = 0;        // 0 idle, 1 between entries, 2 transfer open
    int m_ptr = 0;
    bit m_flag = 0, m_ien = 0, m_hack = 0;
    int m_rx [16];
    bit m_rxv [16];
    int m_tx [16];
    int m_cmd [16];

    always @(posedge clk) begin
        bit hit;
        hit = 0;
        if (rst) begin
            m_st = 0; m_ptr = 0; m_flag = 0; m_ien = 0; m_hack = 0;
        end else begin
            if (run_clr) begin
                m_st = 0; m_hack = 0;
            end else if (m_st == 0) begin
                if (run_set) begin m_st = 1; m_ptr = newq_ptr; end
            end else if (m_st == 1) begin
                if (halt) m_hack = 1;
                else begin m_hack = 0; m_st = 2; end
            end else if (eng_done) begin
                m_rx[m_ptr] = eng_rxd; m_rxv[m_ptr] = 1;
                if (m_ptr == endq_ptr) begin
                    hit = 1;
                    if (wrap_en) begin m_ptr = wrap_to_newq ? newq_ptr : 0; m_st = 1; end
                    else m_st = 0;
                end else begin
                    m_ptr = (m_ptr + 1) % 16; m_st = 1;
                end
            end
            if (!m_flag) m_ien = irq_en;
            if (hit) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
        if (q_we) begin m_tx[q_waddr] = q_wtx; m_cmd[q_waddr] = q_wcmd; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        bit m_start;
        if (!rst) begin
            m_start = (m_st == 2) && !run_clr;
            chk(eng_start == m_start, "R9 eng_start", eng_start, m_start);
            chk(cur_ptr == m_ptr[3:0], "R1 cur_ptr", cur_ptr, m_ptr);
            chk(busy == (m_st != 0), "R1 busy", busy, m_st != 0);
            chk(done_flag == m_flag, "R4 done_flag", done_flag, m_flag);
            chk(irq == (m_flag && m_ien), "R5 irq", irq, m_flag && m_ien);
            chk(halt_ack == m_hack, "R7 halt_ack", halt_ack, m_hack);
            if (m_start) begin
                chk(eng_txd == m_tx[m_ptr][DW-1:0], "R9 eng_txd", eng_txd, m_tx[m_ptr]);
                chk(eng_cmd == m_cmd[m_ptr][CW-1:0], "R9 eng_cmd", eng_cmd, m_cmd[m_ptr]);
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic pulse_run_set();  run_set = 1;  step(); run_set = 0;  endtask
    task automatic pulse_flag_clr(); flag_clr = 1; step(); flag_clr = 0; endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) step();
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 3000 && !done_flag; i++) step();
    endtask

    task automatic check_rx(input string req);
        for (int a = 0; a < 16; a++) begin
            if (m_rxv[a]) begin
                rx_raddr = a[3:0];
                #1;
                chk(rx_rdata == m_rx[a][DW-1:0], req, rx_rdata, m_rx[a]);
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        int p;
        step(3);
        rst = 0;
        step();
        // R10 reset state
        chk(!busy && !done_flag && !irq && !halt_ack && !eng_start && cur_ptr == 0,
            "R10 reset", {busy, done_flag, irq, halt_ack, eng_start}, 0);

        for (int i = 0; i < 16; i++) begin
            q_we = 1; q_waddr = i[3:0]; q_wcmd = CW'(8'h40 + i); q_wtx = DW'(i * 16'h1111);
            step();
        end
        q_we = 0;

        // R1 single pass 2..5, R9 run_set ignored while busy
        newq_ptr = 2; endq_ptr = 5; wrap_en = 0; irq_en = 1;
        pulse_run_set();
        step(4);
        newq_ptr = 9;
        pulse_run_set();
        wait_idle();
        chk(done_flag == 1, "R1 flag after pass", done_flag, 1);
        chk(cur_ptr == 5, "R1 stop at end", cur_ptr, 5);
        chk(irq == 1, "R5 irq with enable", irq, 1);
        check_rx("R3 rx after single pass");
        step(5);
        chk(done_flag == 1, "R4 flag sticky", done_flag, 1);
        pulse_flag_clr();
        chk(done_flag == 0 && irq == 0, "R4 flag cleared", done_flag, 0);

        // R2 wrap to entry 0
        newq_ptr = 3; endq_ptr = 6; wrap_en = 1; wrap_to_newq = 0;
        pulse_run_set();
        wait_flag();
        step();
        chk(busy == 1, "R2 still running after end", busy, 1);
        irq_en = 0;
        step(3);
        chk(irq == 1, "R5 irq kept after enable cleared", irq, 1);
        for (int i = 0; i < 7; i++) begin
            q_we = 1; q_waddr = i[3:0]; q_wcmd = CW'(8'h80 + i); q_wtx = DW'(16'hBEEF - i);
            step();
        end
        q_we = 0;
        step(60);
        pulse_flag_clr();
        step();
        chk(irq == 0, "R5 irq dropped by flag clear", irq, 0);
        wait_flag();
        step();
        chk(done_flag == 1 && irq == 0, "R5 masked request", irq, 0);
        check_rx("R3 rx overwritten by later pass");

        // R6 leave wraparound
        wrap_en = 0;
        wait_idle();
        chk(busy == 0 && cur_ptr == 6, "R6 stop at end after wrap cleared", cur_ptr, 6);

        // R2 wrap to newq, R7 halt, R8 abort
        pulse_flag_clr();
        irq_en = 1;
        newq_ptr = 10; endq_ptr = 12; wrap_en = 1; wrap_to_newq = 1;
        pulse_run_set();
        wait_flag();
        step(5);
        halt = 1;
        for (int i = 0; i < 100 && !halt_ack; i++) step();
        chk(halt_ack == 1, "R7 halt acknowledged", halt_ack, 1);
        for (int i = 0; i < 5; i++) begin
            step();
            chk(eng_start == 0, "R7 no start while halted", eng_start, 0);
        end
        p = cur_ptr;
        halt = 0;
        step(2);
        chk(eng_start == 1 && cur_ptr == p[3:0], "R7 resume at current entry", cur_ptr, p);
        run_clr = 1;
        #1;
        chk(eng_start == 0, "R8 start dropped at once", eng_start, 0);
        step();
        run_clr = 0;
        chk(busy == 0, "R8 run bit cleared", busy, 0);
        step(4);
        check_rx("R8 rx untouched by abort");
        finish_run();
    end
endmodule